// File: doc/BRIEF.md
# NAND Common-Memory Strobe Sequencer

This block turns single-byte read and write requests from a simple synchronous host port into timed strobe sequences for an external NAND flash device. Every access has three programmable phases. The first is a setup phase, where chip enable is low and both strobes are high. The second is a strobe-wait phase, where either the read or the write strobe is low. The third is a hold phase, where chip enable and the address stay put after the strobe rises. On writes, the data bus is kept off for a programmable number of cycles from the start of the access before the write byte is driven. The data bus reaches the pads as separate output, output-enable and input vectors, so the tri-state buffer sits in the pad ring.

Commands and address bytes travel as ordinary writes. Setting address bit 16 raises the command latch line for the write, and setting address bit 17 raises the address latch line. A start address is therefore sent as a run of address-latch writes, lowest byte first. When ready/busy handling is turned on, an active-low busy input stretches the strobe until the device reports ready.

The timing counts sit in four 8-bit registers plus a wait-handling enable. They are written through a one-cycle load strobe and only while the engine is idle. The controller states are IDLE, SETUP, STROBE, HOLD and RECOVER. The transitions are:
- IDLE to SETUP on a request.
- SETUP to STROBE once the setup count has expired.
- STROBE to HOLD once the wait count has expired and the device is not busy.
- HOLD to RECOVER once the hold count has expired.
- RECOVER to IDLE unconditionally, after one cycle.

Top module: `nand_cm_engine`

## Requirements
- R1: After a request is accepted in IDLE, chip enable (active low) goes low and stays low with both strobes high for exactly SET+1 cycles (the setup phase).
- R2: The access strobe (write enable on writes, output enable on reads, both active low) is then low for exactly WAIT+1 cycles when ready/busy handling is off.
- R3: After the strobe rises, chip enable stays low for exactly HOLD+1 cycles with both strobes high. The address output equals the requested address for every cycle in which chip enable is low.
- R4: On a write, the pad output enable is low for the first HIZ cycles of the access (counted from the first cycle with chip enable low). It is then high and carries the write byte up to the last cycle with chip enable low. On a read it is never high.
- R5: Output enable stays high for the whole of a write, and write enable stays high for the whole of a read.
- R6: On a write whose address has bit 16 set, the command latch line is high during every write-strobe cycle. On reads and in idle it is low.
- R7: On a write whose address has bit 17 set, the address latch line is high during every write-strobe cycle, so a start address sent as successive single-byte writes, lowest byte first, is latched byte by byte. It is low on reads.
- R8: With ready/busy handling on, the strobe lasts max(WAIT, B)+1 cycles, where B is the number of strobe cycles ending with the ready/busy input sampled low (busy).
- R9: On a read, the data input is captured on the clock edge that ends the strobe, and it is presented on the read-data output while done is high.
- R10: Done is high for exactly one cycle, the cycle that directly follows the last hold cycle.
- R11: A request that arrives while an access is in progress, including the done cycle, is ignored. Chip enable is high in the done cycle before any new access can start.
- R12: After reset, SET, WAIT, HOLD and HIZ are all 255 and ready/busy handling is off. A configuration load made during an access has no effect.
- R13: During and just after reset, chip enable, write enable and output enable are high, the latch lines and done are low, and the pad output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | One-cycle strobe that loads the timing fields when idle |
| cfg_set | input | 8 | Setup count (phase lasts value+1 cycles) |
| cfg_wait | input | 8 | Strobe count (phase lasts value+1 cycles) |
| cfg_hold | input | 8 | Hold count (phase lasts value+1 cycles) |
| cfg_hiz | input | 8 | Write-data turn-on delay in cycles |
| cfg_wait_en | input | 1 | Enables stretching of the strobe on busy |
| req | input | 1 | Access request, sampled in IDLE |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 26 | Access address; bit 16 selects command latch, bit 17 selects address latch |
| req_wdata | input | 8 | Write byte |
| rd_data | output | 8 | Captured read byte |
| done | output | 1 | One-cycle completion pulse |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_oe_n | output | 1 | Read strobe, active low |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_addr | output | 26 | Address held through the access |
| nand_dq_out | output | 8 | Pad output data |
| nand_dq_oe | output | 1 | Pad output enable |
| nand_dq_in | input | 8 | Pad input data |
| nand_rb_n | input | 1 | Ready/busy, low = busy |

## Verification
The bench measures each phase length in cycles from the pins and compares it with the programmed counts. A design that counted SET rather than SET+1, or that left the strobe one cycle late, would show a length that is off by one. Read data is changed on the bus as soon as the strobe ends, so a capture taken on the wrong edge returns the inverted byte. Busy is released before, at and after the wait count to find a stretch that ignores or double-counts the ready input. Requests and configuration loads are injected in the middle of an access. A design that accepted either one would start a stray access after done or alter the timing of the next access.

// File: rtl/nand_cm_pkg.sv
package nand_cm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SETUP   = 3'd1,
        ST_STROBE  = 3'd2,
        ST_HOLD    = 3'd3,
        ST_RECOVER = 3'd4
    } phase_e;

endpackage

// File: rtl/nand_cm_timing_regs.sv
module nand_cm_timing_regs #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idle,
    input  logic             load,
    input  logic [CNT_W-1:0] set_in,
    input  logic [CNT_W-1:0] wait_in,
    input  logic [CNT_W-1:0] hold_in,
    input  logic [CNT_W-1:0] hiz_in,
    input  logic             wait_en_in,
    output logic [CNT_W-1:0] set_q,
    output logic [CNT_W-1:0] wait_q,
    output logic [CNT_W-1:0] hold_q,
    output logic [CNT_W-1:0] hiz_q,
    output logic             wait_en_q
);

    localparam logic [CNT_W-1:0] SLOWEST = {CNT_W{1'b1}};

    logic take;
    assign take = load && idle;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            set_q     <= SLOWEST;
            wait_q    <= SLOWEST;
            hold_q    <= SLOWEST;
            hiz_q     <= SLOWEST;
            wait_en_q <= 1'b0;
        end else if (take) begin
            set_q     <= set_in;
            wait_q    <= wait_in;
            hold_q    <= hold_in;
            hiz_q     <= hiz_in;
            wait_en_q <= wait_en_in;
        end
    end

    AST_CFG_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |=> $stable({set_q, wait_q, hold_q, hiz_q, wait_en_q})); // R12

endmodule

// File: rtl/nand_cm_phase_fsm.sv
module nand_cm_phase_fsm
    import nand_cm_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int EL_W  = CNT_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [CNT_W-1:0] set_q,
    input  logic [CNT_W-1:0] wait_q,
    input  logic [CNT_W-1:0] hold_q,
    input  logic             wait_en_q,
    input  logic             rb_n,
    output phase_e           state,
    output logic             accept,
    output logic             strobe_exit,
    output logic [EL_W-1:0]  elapsed
);

    localparam logic [EL_W-1:0] EL_MAX = {EL_W{1'b1}};

    phase_e           nxt;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;
    logic             stall;
    logic             active;

    assign stall  = wait_en_q && !rb_n;
    assign active = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD);

    always_comb begin
        limit = '0;
        unique case (state)
            ST_SETUP:  limit = set_q;
            ST_STROBE: limit = wait_q;
            ST_HOLD:   limit = hold_q;
            default:   limit = '0;
        endcase
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (req) nxt = ST_SETUP;
            ST_SETUP:   if (cnt == set_q) nxt = ST_STROBE;
            ST_STROBE:  if ((cnt == wait_q) && !stall) nxt = ST_HOLD;
            ST_HOLD:    if (cnt == hold_q) nxt = ST_RECOVER;
            ST_RECOVER: nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    assign accept      = (state == ST_IDLE) && req;
    assign strobe_exit = (state == ST_STROBE) && (nxt == ST_HOLD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (nxt != state) begin
            cnt <= '0;
        end else if (cnt != limit) begin
            cnt <= cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            elapsed <= '0;
        end else if (accept) begin
            elapsed <= '0;
        end else if (active && (elapsed != EL_MAX)) begin
            elapsed <= elapsed + 1'b1;
        end
    end

    AST_SETUP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SETUP) |-> (cnt <= set_q)); // R1
    AST_STROBE_FROM_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_STROBE) && ($past(state) != ST_STROBE)) |-> ($past(state) == ST_SETUP)); // R2
    AST_BUSY_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_STROBE) && wait_en_q && !rb_n) |=> (state == ST_STROBE)); // R8
    AST_RECOVER_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RECOVER) |=> (state == ST_IDLE)); // R11

endmodule

// File: rtl/nand_cm_bus_drive.sv
module nand_cm_bus_drive
    import nand_cm_pkg::*;
#(
    parameter int ADDR_W  = 26,
    parameter int DATA_W  = 8,
    parameter int CNT_W   = 8,
    parameter int EL_W    = CNT_W + 2,
    parameter int CMD_BIT = 16,
    parameter int ALE_BIT = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_e            state,
    input  logic              accept,
    input  logic              strobe_exit,
    input  logic [EL_W-1:0]   elapsed,
    input  logic [CNT_W-1:0]  hiz_q,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] dq_in,
    output logic              ce_n,
    output logic              oe_n,
    output logic              we_n,
    output logic              cle,
    output logic              ale,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic [DATA_W-1:0] rd_data,
    output logic              done
);

    logic              wr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              busy;
    logic              strobing;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            wr_q    <= req_wr;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (strobe_exit && !wr_q) begin
            rd_data <= dq_in;
        end
    end

    always_comb begin
        busy     = 1'b0;
        strobing = 1'b0;
        done     = 1'b0;
        unique case (state)
            ST_IDLE:    busy = 1'b0;
            ST_SETUP:   busy = 1'b1;
            ST_STROBE: begin
                busy     = 1'b1;
                strobing = 1'b1;
            end
            ST_HOLD:    busy = 1'b1;
            ST_RECOVER: done = 1'b1;
            default:    busy = 1'b0;
        endcase
    end

    assign ce_n   = !busy;
    assign we_n   = !(strobing && wr_q);
    assign oe_n   = !(strobing && !wr_q);
    assign cle    = busy && wr_q && addr_q[CMD_BIT];
    assign ale    = busy && wr_q && addr_q[ALE_BIT];
    assign addr   = addr_q;
    assign dq_out = wdata_q;
    assign dq_oe  = busy && wr_q && (elapsed >= EL_W'(hiz_q));

    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!oe_n && !we_n)); // R5
    AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (oe_n && !ce_n)); // R4
    AST_LATCH_NOT_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (cle || ale) |-> oe_n); // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_CE_HIGH_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ce_n); // R11
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && $past(!ce_n)) |-> $stable(addr)); // R3

endmodule

// File: rtl/nand_cm_engine.sv
module nand_cm_engine
    import nand_cm_pkg::*;
#(
    parameter int ADDR_W  = 26,
    parameter int DATA_W  = 8,
    parameter int CNT_W   = 8,
    parameter int CMD_BIT = 16,
    parameter int ALE_BIT = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic [CNT_W-1:0]  cfg_set,
    input  logic [CNT_W-1:0]  cfg_wait,
    input  logic [CNT_W-1:0]  cfg_hold,
    input  logic [CNT_W-1:0]  cfg_hiz,
    input  logic              cfg_wait_en,
    input  logic              req,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic              nand_ce_n,
    output logic              nand_oe_n,
    output logic              nand_we_n,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic [ADDR_W-1:0] nand_addr,
    output logic [DATA_W-1:0] nand_dq_out,
    output logic              nand_dq_oe,
    input  logic [DATA_W-1:0] nand_dq_in,
    input  logic              nand_rb_n
);

    localparam int EL_W = CNT_W + 2;

    phase_e           state;
    logic             accept;
    logic             strobe_exit;
    logic [EL_W-1:0]  elapsed;
    logic [CNT_W-1:0] set_q;
    logic [CNT_W-1:0] wait_q;
    logic [CNT_W-1:0] hold_q;
    logic [CNT_W-1:0] hiz_q;
    logic             wait_en_q;

    nand_cm_timing_regs #(.CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .idle       (state == ST_IDLE),
        .load       (cfg_load),
        .set_in     (cfg_set),
        .wait_in    (cfg_wait),
        .hold_in    (cfg_hold),
        .hiz_in     (cfg_hiz),
        .wait_en_in (cfg_wait_en),
        .set_q      (set_q),
        .wait_q     (wait_q),
        .hold_q     (hold_q),
        .hiz_q      (hiz_q),
        .wait_en_q  (wait_en_q)
    );

    nand_cm_phase_fsm #(.CNT_W(CNT_W), .EL_W(EL_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (req),
        .set_q       (set_q),
        .wait_q      (wait_q),
        .hold_q      (hold_q),
        .wait_en_q   (wait_en_q),
        .rb_n        (nand_rb_n),
        .state       (state),
        .accept      (accept),
        .strobe_exit (strobe_exit),
        .elapsed     (elapsed)
    );

    nand_cm_bus_drive #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .CNT_W   (CNT_W),
        .EL_W    (EL_W),
        .CMD_BIT (CMD_BIT),
        .ALE_BIT (ALE_BIT)
    ) u_bus (
        .clk         (clk),
        .rst_n       (rst_n),
        .state       (state),
        .accept      (accept),
        .strobe_exit (strobe_exit),
        .elapsed     (elapsed),
        .hiz_q       (hiz_q),
        .req_wr      (req_wr),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .dq_in       (nand_dq_in),
        .ce_n        (nand_ce_n),
        .oe_n        (nand_oe_n),
        .we_n        (nand_we_n),
        .cle         (nand_cle),
        .ale         (nand_ale),
        .addr        (nand_addr),
        .dq_out      (nand_dq_out),
        .dq_oe       (nand_dq_oe),
        .rd_data     (rd_data),
        .done        (done)
    );

endmodule

// File: tb/tb_nand_cm_engine.sv
module tb_nand_cm_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_load = 1'b0;
    logic [7:0]  cfg_set = '0, cfg_wait = '0, cfg_hold = '0, cfg_hiz = '0;
    logic        cfg_wait_en = 1'b0;
    logic        req = 1'b0, req_wr = 1'b0;
    logic [25:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  rd_data;
    logic        done;
    logic        ce_n, oe_n, we_n, cle, ale;
    logic [25:0] nand_addr;
    logic [7:0]  dq_out;
    logic        dq_oe;
    logic [7:0]  dq_in = '0;
    logic        rb_n = 1'b1;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 1'b0;

    int c_set = 255, c_wait = 255, c_hold = 255, c_hiz = 255;
    bit c_wen = 1'b0;

    always #2 clk = ~clk;

    nand_cm_engine dut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_set(cfg_set),
        .cfg_wait(cfg_wait), .cfg_hold(cfg_hold), .cfg_hiz(cfg_hiz),
        .cfg_wait_en(cfg_wait_en), .req(req), .req_wr(req_wr),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
        .done(done), .nand_ce_n(ce_n), .nand_oe_n(oe_n), .nand_we_n(we_n),
        .nand_cle(cle), .nand_ale(ale), .nand_addr(nand_addr),
        .nand_dq_out(dq_out), .nand_dq_oe(dq_oe), .nand_dq_in(dq_in),
        .nand_rb_n(rb_n)
    );

    task automatic check(input bit ok, input string req_tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req_tag, act, exp);
        end
    endtask

    function automatic int exp_strobe(input int w, input int b, input bit wen);
        if (wen && b > w) return b + 1;
        return w + 1;
    endfunction

    function automatic int exp_drive(input bit wr, input int z, input int total);
        if (!wr || z >= total) return -1;
        return z;
    endfunction

    task automatic load_cfg(input int s, input int w, input int h, input int z, input bit wen);
        @(negedge clk);
        cfg_load = 1'b1;
        cfg_set = 8'(s); cfg_wait = 8'(w); cfg_hold = 8'(h); cfg_hiz = 8'(z);
        cfg_wait_en = wen;
        @(negedge clk);
        cfg_load = 1'b0;
        c_set = s; c_wait = w; c_hold = h; c_hiz = z; c_wen = wen;
    endtask

    task automatic access(input bit wr, input logic [25:0] a, input logic [7:0] wd,
                          input logic [7:0] rv, input int b, input bit inject);
        int nset = 0, nstr = 0, nhold = 0, first_drv = -1, i = 0;
        bit bad_other = 0, bad_lat = 0, bad_addr = 0, bad_drv = 0, bad_order = 0;
        bit cmd_exp = wr && a[16];
        bit ale_exp = wr && a[17];
        int es, total;
        logic [7:0] got_rd = '0;
        bit got_done = 0;
        @(negedge clk);
        req = 1'b1; req_wr = wr; req_addr = a; req_wdata = wd;
        rb_n = (b == 0);
        dq_in = ~rv;
        @(negedge clk);
        req = 1'b0;
        if (inject) begin
            req = 1'b1; req_wr = ~wr; req_addr = ~a; req_wdata = ~wd;
            cfg_load = 1'b1; cfg_set = 8'd0; cfg_wait = 8'd0; cfg_hold = 8'd0; cfg_hiz = 8'd0;
        end
        while (i < 6000) begin
            if (ce_n) begin
                got_done = done;
                got_rd = rd_data;
                break;
            end
            if (nand_addr != a) bad_addr = 1;
            if (wr ? !oe_n : !we_n) bad_other = 1;
            if (!wr && (cle || ale)) bad_lat = 1;
            if (wr ? !we_n : !oe_n) begin
                if (nhold != 0) bad_order = 1;
                nstr++;
                if (wr && (cle != cmd_exp || ale != ale_exp)) bad_lat = 1;
                rb_n = (nstr - 1 >= b);
            end else if (nstr == 0) nset++;
            else nhold++;
            if (dq_oe) begin
                if (first_drv < 0) first_drv = i;
                if (dq_out != wd) bad_drv = 1;
            end else if (first_drv >= 0) bad_drv = 1;
            dq_in = !oe_n ? rv : ~rv;
            @(negedge clk);
            if (inject && i == 0) begin
                req = 1'b0; cfg_load = 1'b0;
            end
            i++;
        end
        es = exp_strobe(c_wait, b, c_wen);
        total = c_set + 1 + es + c_hold + 1;
        check(nset == c_set + 1, "R1 setup cycles", nset, c_set + 1);
        check(nstr == es, c_wen ? "R8 stretched strobe cycles" : "R2 strobe cycles", nstr, es);
        check(nhold == c_hold + 1 && !bad_order, "R3 hold cycles", nhold, c_hold + 1);
        check(!bad_addr, "R3 address stable", bad_addr, 0);
        check(first_drv == exp_drive(wr, c_hiz, total) && !bad_drv, "R4 write-data drive start",
              first_drv, exp_drive(wr, c_hiz, total));
        check(!bad_other, "R5 inactive strobe stays high", bad_other, 0);
        check(!bad_lat, ale_exp ? "R7 address latch" : "R6 command latch", bad_lat, 0);
        check(got_done, "R10 done after hold", got_done, 1);
        if (!wr) check(got_rd == rv, "R9 captured read byte", got_rd, rv);
        rb_n = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(!done && ce_n, "R10 R11 done single, no stray access", {done, ce_n}, 1);
        end
    endtask

    initial begin
        while (!finished) begin
            @(posedge clk);
            cyc++;
            if (cyc > 190000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 190000);
                $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        logic [25:0] start_ad;
        void'($urandom(32'h1A2B3C4D));
        repeat (3) @(negedge clk);
        check(ce_n && oe_n && we_n && !cle && !ale && !done && !dq_oe, "R13 reset outputs",
              {ce_n, oe_n, we_n, cle, ale, done, dq_oe}, 7'b1110000);
        rst_n = 1'b1;
        @(negedge clk);
        check(ce_n && !done && !dq_oe, "R13 outputs after reset", {ce_n, done, dq_oe}, 3'b100);
        // R12: reset timing 255/255/255/255, wait handling off
        access(1'b1, 26'h0012345, 8'h5A, 8'h00, 0, 1'b0);
        load_cfg(2, 3, 1, 2, 1'b0);
        // R6: command write (bit 16)
        access(1'b1, 26'h0010000, 8'h00, 8'h00, 0, 1'b0);
        // R7: start address, lowest byte first, on address-latch writes (bit 17)
        start_ad = 26'h2ABCDEF;
        for (int k = 0; k < 4; k++)
            access(1'b1, 26'h0020000, start_ad[8*k +: 8], 8'h00, 0, 1'b0);
        // R9 / R8 directed
        access(1'b0, 26'h0000100, 8'h00, 8'hC3, 0, 1'b0);
        load_cfg(0, 1, 0, 0, 1'b1);
        access(1'b0, 26'h0000200, 8'h00, 8'h3C, 5, 1'b0);
        access(1'b0, 26'h0000201, 8'h00, 8'h96, 1, 1'b0);
        access(1'b1, 26'h0000202, 8'hE1, 8'h00, 2, 1'b0);
        // R11 / R12: request and config load injected mid-access
        load_cfg(1, 2, 2, 1, 1'b0);
        access(1'b1, 26'h0000303, 8'h77, 8'h00, 0, 1'b1);
        access(1'b0, 26'h0000304, 8'h00, 8'h18, 0, 1'b0);
        for (int n = 0; n < 60; n++) begin
            int s = $urandom_range(0, 4);
            int w = $urandom_range(0, 4);
            int h = $urandom_range(0, 4);
            int z = $urandom_range(0, 14);
            bit wen = 1'($urandom_range(0, 1));
            bit wr = 1'($urandom_range(0, 1));
            logic [25:0] a = 26'($urandom);
            load_cfg(s, w, h, z, wen);
            access(wr, a, 8'($urandom), 8'($urandom), $urandom_range(0, 6),
                   ($urandom_range(0, 3) == 0));
        end
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule